// File: doc/BRIEF.md
# Segmented Mailbox Transmitter

This block moves one outgoing message of up to 2048 bytes into a small mailbox window on the far side of a link. The window holds one segment: an 8-byte header plus at most 48 payload bytes. The block therefore cuts the message into consecutive 48-byte pieces. For each piece it clears the far end's status word and writes the header and the payload dwords into the window. It then writes an attribute word and a control word that start the transfer, and waits for the far end to write back a completion status before it moves on to the next piece.

A requester presents the message length, module and command codes, destination function, destination event queue, direction and an acknowledge-suppress flag. It then pulses `req_valid`. The block fetches payload dwords itself through a combinational read port into the caller's buffer. Each request ends with a one-cycle `done` pulse, or with an `err` pulse that carries either the far end's error code or a timeout indication. The remaining segments are abandoned in both error cases.

Top module: `mbx_seg_tx`

## Requirements
- R1: A message of L bytes is sent as max(1, ceil(L/48)) segments. Segment s carries message bytes 48*s onward, and its header sequence field holds s, counting up from 0.
- R2: Every segment except the final one carries a segment-length field of 48 and a clear last flag. The final segment carries the remaining byte count L-48*s, which may be 0 for an empty message, and a set last flag.
- R3: Header dword 0 holds, from bit 0 upward: message length [11:0], segment length [17:12], sequence [23:18], last [24], direction [25], no-ack [26], zero [27] and message id [31:28]. Header dword 1 holds module [7:0], command [23:8] and zero [31:24].
- R4: Every dword written to window addresses 0..13 is byte-swapped relative to its little-endian value (byte 0 lands in bits 31:24). Only ceil(seglen/4) payload dwords are written, at addresses 2 upward. Bytes past the segment end in the final dword are written as zero.
- R5: The per-segment order is: a one-cycle `wb_clr` pulse, then header dword 0 (address 0), header dword 1 (address 1), the payload dwords, the attribute word (address 14) and the control word (address 15), one write per cycle.
- R6: The attribute word is written unswapped. It holds the destination queue in [11:10], ceil((seglen+8)/4) in [24:20] and a 1 in bit 28, with every other bit zero.
- R7: The control word is written unswapped. It holds the destination function in [28:16], a 1 in bit 1 and a 0 in bit 0, with every other bit zero.
- R8: While waiting, a status low byte of 0x00 means keep waiting. 0xFF means the segment succeeded, which leads to the next segment or to `done`. Any other value ends the request with `err`, `err_code` = status[15:8] and `err_timeout` = 0, and no further window writes follow.
- R9: If no finished status is seen within TIMEOUT_CYC cycles of waiting, the request ends with `err`, `err_timeout` = 1 and `err_code` = 0. A status that arrives in the last allowed cycle counts as success.
- R10: Each accepted request takes message id (previous id + 1) mod 16. The first id after reset is 1.
- R11: `busy` rises in the cycle after acceptance and falls in the cycle where `done` or `err` pulses. `req_valid` while `busy` is high has no effect.
- R12: After reset `busy`, `done`, `err`, `win_we`, `wb_clr`, `err_code` and `err_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_len | input | 12 | Message length in bytes, 0..2048 |
| req_module | input | 8 | Module code placed in the header |
| req_cmd | input | 16 | Command code placed in the header |
| req_dst_func | input | 13 | Destination function for the control word |
| req_aeq | input | 2 | Destination event queue for the attribute word |
| req_dir | input | 1 | Direction flag placed in the header |
| req_no_ack | input | 1 | Acknowledge-suppress flag placed in the header |
| buf_addr | output | 9 | Dword index into the message buffer |
| buf_data | input | 32 | Little-endian buffer dword at `buf_addr` (same cycle) |
| win_we | output | 1 | Window write strobe |
| win_addr | output | 4 | Window dword address (0..13 data, 14 attribute, 15 control) |
| win_wdata | output | 32 | Window write data |
| wb_clr | output | 1 | Clears the far end's write-back status word |
| wb_status | input | 16 | Write-back status: [7:0] state, [15:8] error code |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: every segment succeeded |
| err | output | 1 | One-cycle pulse: request aborted |
| err_code | output | 8 | Far-end error code, valid with `err` |
| err_timeout | output | 1 | Abort caused by timeout, valid with `err` |

## Verification
Two functions can fall in the same cycle: the wait counter reaching its limit, and the far end's success status arriving. The bench provokes this with a responder that posts the status a programmed number of waiting cycles after the control write. It runs once with the status landing exactly in the final allowed cycle, where `done` and no `err` are required, and once one cycle later, where a timeout `err` with a zero code is required. A second overlap is a new `req_valid` presented while a transfer is under way. That case is judged by comparing the full window write stream and the next request's message id against the undisturbed expectation.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;

    localparam int SEG_BYTES = 48;
    localparam int MAX_BYTES = 2048;
    localparam int SEG_DW    = SEG_BYTES / 4;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int SLEN_W    = $clog2(SEG_BYTES + 1);
    localparam int SEQ_W     = $clog2(MAX_BYTES / SEG_BYTES + 1);
    localparam int BUF_AW    = $clog2(MAX_BYTES / 4);
    localparam int DW_IDX_W  = $clog2(SEG_DW);
    localparam int WIN_AW    = 4;
    localparam int WIN_PAY0  = 2;
    localparam int WIN_ATTR  = 14;
    localparam int WIN_CTRL  = 15;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CLR, ST_HDR0, ST_HDR1, ST_PAY, ST_ATTR, ST_CTRL, ST_WAIT
    } tx_state_e;

    typedef struct packed {
        logic [7:0]       module_id;
        logic [15:0]      cmd;
        logic [12:0]      dst_func;
        logic [1:0]       aeq;
        logic             dir;
        logic             no_ack;
        logic [LEN_W-1:0] len;
        logic [3:0]       msg_id;
    } tx_req_t;

    typedef struct packed {
        logic [SLEN_W-1:0] seg_len;
        logic              last;
        logic [SEQ_W-1:0]  seq;
        logic [BUF_AW-1:0] base_dw;
    } seg_info_t;

    function automatic logic [31:0] swap32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [4:0] tx_units(input logic [SLEN_W-1:0] seg_len);
        logic [7:0] t;
        t = 8'(seg_len) + 8'd11;
        return t[6:2];
    endfunction

    function automatic logic [31:0] hdr_lo(input tx_req_t r, input seg_info_t s);
        return {r.msg_id, 1'b0, r.no_ack, r.dir, s.last, s.seq, s.seg_len, r.len};
    endfunction

    function automatic logic [31:0] hdr_hi(input tx_req_t r);
        return {8'h00, r.cmd, r.module_id};
    endfunction

    function automatic logic [31:0] attr_word(input logic [1:0] aeq,
                                              input logic [SLEN_W-1:0] seg_len);
        return {3'b000, 1'b1, 1'b0, 2'b00, tx_units(seg_len), 6'b0, 2'b00, aeq, 10'b0};
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [12:0] dst);
        return {3'b000, dst, 14'b0, 1'b1, 1'b0};
    endfunction

endpackage

// File: rtl/mbx_seg_track.sv
module mbx_seg_track
    import mbx_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             advance,
    output seg_info_t        info
);
    logic [LEN_W-1:0]  remain_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [BUF_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            seq_q    <= '0;
            base_q   <= '0;
        end else if (load) begin
            remain_q <= len;
            seq_q    <= '0;
            base_q   <= '0;
        end else if (advance) begin
            remain_q <= remain_q - LEN_W'(SEG_BYTES);
            seq_q    <= seq_q + 1'b1;
            base_q   <= base_q + BUF_AW'(SEG_DW);
        end
    end

    always_comb begin
        info.last    = (remain_q <= LEN_W'(SEG_BYTES));
        info.seg_len = info.last ? remain_q[SLEN_W-1:0] : SLEN_W'(SEG_BYTES);
        info.seq     = seq_q;
        info.base_dw = base_q;
    end

endmodule

// File: rtl/mbx_word_fmt.sv
module mbx_word_fmt
    import mbx_tx_pkg::*;
(
    input  tx_state_e            state,
    input  logic [DW_IDX_W-1:0]  k,
    input  tx_req_t              req,
    input  seg_info_t            info,
    input  logic [31:0]          buf_data,
    output logic [BUF_AW-1:0]    buf_addr,
    output logic                 win_we,
    output logic [WIN_AW-1:0]    win_addr,
    output logic [31:0]          win_wdata
);
    logic [31:0] pay;

    assign buf_addr = info.base_dw + BUF_AW'(k);

    always_comb begin
        pay = buf_data;
        for (int j = 0; j < 4; j++) begin
            if (int'(k) * 4 + j >= int'(info.seg_len))
                pay[8*j +: 8] = 8'h00;
        end
    end

    always_comb begin
        win_we    = 1'b1;
        win_addr  = '0;
        win_wdata = '0;
        unique case (state)
            ST_HDR0: begin
                win_addr  = '0;
                win_wdata = swap32(hdr_lo(req, info));
            end
            ST_HDR1: begin
                win_addr  = WIN_AW'(1);
                win_wdata = swap32(hdr_hi(req));
            end
            ST_PAY: begin
                win_addr  = WIN_AW'(WIN_PAY0) + WIN_AW'(k);
                win_wdata = swap32(pay);
            end
            ST_ATTR: begin
                win_addr  = WIN_AW'(WIN_ATTR);
                win_wdata = attr_word(req.aeq, info.seg_len);
            end
            ST_CTRL: begin
                win_addr  = WIN_AW'(WIN_CTRL);
                win_wdata = ctrl_word(req.dst_func);
            end
            default: win_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbx_wb_wait.sv
module mbx_wb_wait #(
    parameter int TIMEOUT_CYC = 800_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic [7:0] wb_state,
    output logic       ok,
    output logic       fail,
    output logic       expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             finished;

    always_ff @(posedge clk) begin
        if (rst || !active) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign finished = (wb_state != 8'h00);
    assign ok       = active && (wb_state == 8'hFF);
    assign fail     = active && finished && (wb_state != 8'hFF);
    assign expire   = active && !finished && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/mbx_seg_tx.sv
module mbx_seg_tx
    import mbx_tx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 800_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [11:0] req_len,
    input  logic [7:0]  req_module,
    input  logic [15:0] req_cmd,
    input  logic [12:0] req_dst_func,
    input  logic [1:0]  req_aeq,
    input  logic        req_dir,
    input  logic        req_no_ack,
    output logic [8:0]  buf_addr,
    input  logic [31:0] buf_data,
    output logic        win_we,
    output logic [3:0]  win_addr,
    output logic [31:0] win_wdata,
    output logic        wb_clr,
    input  logic [15:0] wb_status,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  err_code,
    output logic        err_timeout
);
    tx_state_e            state_q;
    tx_req_t              req_q;
    seg_info_t            info;
    logic [DW_IDX_W-1:0]  k_q;
    logic [3:0]           id_q;
    logic                 done_q, err_q, tmo_q;
    logic [7:0]           code_q;
    logic                 accept, advance;
    logic                 w_ok, w_fail, w_expire;
    logic [6:0]           dw_sum;
    logic [DW_IDX_W-1:0]  n_dw;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign advance = w_ok && !info.last;
    assign dw_sum  = 7'(info.seg_len) + 7'd3;
    assign n_dw    = DW_IDX_W'(dw_sum >> 2);

    mbx_seg_track u_track (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .len     (req_len),
        .advance (advance),
        .info    (info)
    );

    mbx_word_fmt u_fmt (
        .state     (state_q),
        .k         (k_q),
        .req       (req_q),
        .info      (info),
        .buf_data  (buf_data),
        .buf_addr  (buf_addr),
        .win_we    (win_we),
        .win_addr  (win_addr),
        .win_wdata (win_wdata)
    );

    mbx_wb_wait #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .active   (state_q == ST_WAIT),
        .wb_state (wb_status[7:0]),
        .ok       (w_ok),
        .fail     (w_fail),
        .expire   (w_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            k_q     <= '0;
            id_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
            code_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.module_id <= req_module;
                        req_q.cmd       <= req_cmd;
                        req_q.dst_func  <= req_dst_func;
                        req_q.aeq       <= req_aeq;
                        req_q.dir       <= req_dir;
                        req_q.no_ack    <= req_no_ack;
                        req_q.len       <= req_len;
                        req_q.msg_id    <= id_q + 4'd1;
                        id_q            <= id_q + 4'd1;
                        state_q         <= ST_CLR;
                    end
                end
                ST_CLR:  state_q <= ST_HDR0;
                ST_HDR0: state_q <= ST_HDR1;
                ST_HDR1: begin
                    k_q     <= '0;
                    state_q <= (n_dw == '0) ? ST_ATTR : ST_PAY;
                end
                ST_PAY: begin
                    if (k_q == n_dw - 1'b1) state_q <= ST_ATTR;
                    else                    k_q     <= k_q + 1'b1;
                end
                ST_ATTR: state_q <= ST_CTRL;
                ST_CTRL: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (w_ok) begin
                        if (info.last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_CLR;
                        end
                    end else if (w_fail) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                        tmo_q   <= 1'b0;
                        code_q  <= wb_status[15:8];
                    end else if (w_expire) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                        tmo_q   <= 1'b1;
                        code_q  <= 8'h00;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wb_clr      = (state_q == ST_CLR);
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign err         = err_q;
    assign err_code    = code_q;
    assign err_timeout = tmo_q;

endmodule

// File: rtl/mbx_seg_tx_chk.sv
module mbx_seg_tx_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        win_we,
    input logic [3:0]  win_addr,
    input logic [31:0] win_wdata,
    input logic        wb_clr,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [7:0]  err_code,
    input logic        err_timeout
);
    p_end_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_idle_on_end_r11: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);

    p_start_by_req_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    p_clr_before_hdr_r5: assert property (@(posedge clk) disable iff (rst)
        (win_we && win_addr == 4'd0) |-> $past(wb_clr));

    p_ctrl_after_attr_r5: assert property (@(posedge clk) disable iff (rst)
        (win_we && win_addr == 4'd15) |-> $past(win_we && win_addr == 4'd14));

    p_attr_fields_r6: assert property (@(posedge clk) disable iff (rst)
        (win_we && win_addr == 4'd14) |->
            (win_wdata[28] && win_wdata[19:14] == 6'd0 && win_wdata[26:25] == 2'd0
             && win_wdata[24:20] >= 5'd2 && win_wdata[24:20] <= 5'd14));

    p_ctrl_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (win_we && win_addr == 4'd15) |-> (win_wdata[1:0] == 2'b10));

    p_tmo_code_r9: assert property (@(posedge clk) disable iff (rst)
        (err && err_timeout) |-> (err_code == 8'h00));

endmodule

bind mbx_seg_tx mbx_seg_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .win_we      (win_we),
    .win_addr    (win_addr),
    .win_wdata   (win_wdata),
    .wb_clr      (wb_clr),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .err_code    (err_code),
    .err_timeout (err_timeout)
);

// File: tb/sim_mbx_seg_tx.sv
`timescale 1ns/1ps
module sim_mbx_seg_tx;
    localparam int TMO = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_len = '0;
    logic [7:0]  req_module = '0;
    logic [15:0] req_cmd = '0;
    logic [12:0] req_dst_func = '0;
    logic [1:0]  req_aeq = '0;
    logic        req_dir = 1'b0;
    logic        req_no_ack = 1'b0;
    logic [8:0]  buf_addr;
    logic [31:0] buf_data;
    logic        win_we;
    logic [3:0]  win_addr;
    logic [31:0] win_wdata;
    logic        wb_clr;
    logic [15:0] wb_status = '0;
    logic        busy, done, err, err_timeout;
    logic [7:0]  err_code;

    always #5 clk = ~clk;

    mbx_seg_tx #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
        .req_module(req_module), .req_cmd(req_cmd), .req_dst_func(req_dst_func),
        .req_aeq(req_aeq), .req_dir(req_dir), .req_no_ack(req_no_ack),
        .buf_addr(buf_addr), .buf_data(buf_data), .win_we(win_we),
        .win_addr(win_addr), .win_wdata(win_wdata), .wb_clr(wb_clr),
        .wb_status(wb_status), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .err_timeout(err_timeout)
    );

    logic [7:0] mem [0:2047];
    always_comb buf_data = {mem[{buf_addr, 2'd3}], mem[{buf_addr, 2'd2}],
                            mem[{buf_addr, 2'd1}], mem[{buf_addr, 2'd0}]};

    int n_chk = 0;
    int n_bad = 0;
    int exp_id = 0;

    logic [3:0]  la [0:1023];
    logic [31:0] ld [0:1023];
    int nlog = 0, nclr = 0, nctrl = 0;
    int lat = 2;
    int fail_seg = -1;
    logic [15:0] fail_val = 16'h0000;
    logic [15:0] resp_val = 16'h00FF;
    bit armed = 0;
    int cd = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (win_we) begin
                la[nlog % 1024] = win_addr;
                ld[nlog % 1024] = win_wdata;
                nlog++;
            end
            if (wb_clr) begin
                wb_status = 16'h0000;
                armed = 0;
                nclr++;
            end else if (win_we && win_addr == 4'd15) begin
                armed = 1;
                cd = lat;
                resp_val = (nctrl == fail_seg) ? fail_val : 16'h00FF;
                nctrl++;
            end else if (armed) begin
                if (cd == 0) begin
                    wb_status = resp_val;
                    armed = 0;
                end else begin
                    cd--;
                end
            end
        end
    end

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (got hung, expected completion)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    bit          r_done, r_err, r_tmo;
    logic [7:0]  r_code;
    int          b_log, b_clr;

    task automatic set_req(input int len, input logic [7:0] md, input logic [15:0] cm,
                           input logic [12:0] df, input logic [1:0] aq,
                           input bit dr, input bit na);
        req_len = 12'(len); req_module = md; req_cmd = cm;
        req_dst_func = df; req_aeq = aq; req_dir = dr; req_no_ack = na;
    endtask

    task automatic wait_end();
        r_done = 0; r_err = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done || err) begin
                r_done = done; r_err = err; r_tmo = err_timeout; r_code = err_code;
                break;
            end
        end
    endtask

    task automatic send();
        b_log = nlog; b_clr = nclr;
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        exp_id = (exp_id + 1) % 16;
        wait_end();
    endtask

    // expected window stream for the first nsent segments of the current request
    task automatic check_stream(input int nsent, input string tag);
        logic [35:0] q[$];
        int L, nseg, seglen, ndw, idx;
        bit ok;
        logic [31:0] a_d, e_d;
        logic [3:0] a_a, e_a;
        L = int'(req_len);
        nseg = (L == 0) ? 1 : (L + 47) / 48;
        for (int s = 0; s < nsent; s++) begin
            bit last;
            last = (s == nseg - 1);
            seglen = last ? L - 48 * s : 48;
            q.push_back({4'd0, sw({4'(exp_id), 1'b0, req_no_ack, req_dir, last,
                                   6'(s), 6'(seglen), 12'(L)})});
            q.push_back({4'd1, sw({8'h00, req_cmd, req_module})});
            ndw = (seglen + 3) / 4;
            for (int k = 0; k < ndw; k++) begin
                logic [7:0] b [4];
                for (int j = 0; j < 4; j++)
                    b[j] = (4 * k + j < seglen) ? mem[48 * s + 4 * k + j] : 8'h00;
                q.push_back({4'(2 + k), b[0], b[1], b[2], b[3]});
            end
            q.push_back({4'd14, 3'b000, 1'b1, 3'b000, 5'((seglen + 11) / 4),
                         6'b0, 2'b00, req_aeq, 10'b0});
            q.push_back({4'd15, 3'b000, req_dst_func, 14'b0, 2'b10});
        end
        check(nlog - b_log == q.size(), tag, "window write count",
              32'(nlog - b_log), 32'(q.size()));
        ok = 1; a_d = '0; e_d = '0; a_a = '0; e_a = '0;
        for (int i = 0; i < q.size() && i < nlog - b_log; i++) begin
            idx = (b_log + i) % 1024;
            if (ok && {la[idx], ld[idx]} != q[i]) begin
                ok = 0; a_a = la[idx]; a_d = ld[idx]; e_a = q[i][35:32]; e_d = q[i][31:0];
            end
        end
        check(ok, tag, "window write data", a_d ^ {28'b0, a_a}, e_d ^ {28'b0, e_a});
        check(nclr - b_clr == nsent, tag, "status clears", 32'(nclr - b_clr), 32'(nsent));
    endtask

    task automatic t_reset();
        check(!busy && !done && !err && !win_we && !wb_clr, "R12", "idle outputs",
              {27'b0, busy, done, err, win_we, wb_clr}, 32'd0);
        check(err_code == 8'h00 && !err_timeout, "R12", "error fields",
              {23'b0, err_timeout, err_code}, 32'd0);
    endtask

    task automatic t_short();
        set_req(5, 8'h3C, 16'hBEEF, 13'h0A5, 2'd2, 1'b1, 1'b0);
        send();
        check(r_done && !r_err, "R8", "short msg done", {31'b0, r_done}, 32'd1);
        check_stream(1, "R4");
    endtask

    task automatic t_len(input int L, input string tag);
        set_req(L, 8'(L), 16'(L * 7), 13'h1FFF, 2'(L), L[0], ~L[0]);
        send();
        check(r_done && !r_err, tag, "done pulse", {31'b0, r_done}, 32'd1);
        check_stream((L == 0) ? 1 : (L + 47) / 48, tag);
    endtask

    task automatic t_fail();
        set_req(100, 8'h11, 16'h2222, 13'h0003, 2'd1, 1'b0, 1'b1);
        fail_seg = nctrl + 1; fail_val = 16'h5A11;
        send();
        fail_seg = -1;
        check(r_err && !r_done, "R8", "fail gives err", {31'b0, r_err}, 32'd1);
        check(r_code == 8'h5A && !r_tmo, "R8", "fail code", {23'b0, r_tmo, r_code}, 32'h5A);
        repeat (5) @(negedge clk);
        check_stream(2, "R8");
    endtask

    task automatic t_edge();
        set_req(10, 8'h01, 16'h0002, 13'h0004, 2'd3, 1'b0, 1'b0);
        lat = TMO - 1;
        send();
        check(r_done && !r_err, "R9", "status in last cycle wins", {31'b0, r_done}, 32'd1);
        lat = TMO;
        send();
        check(r_err && r_tmo, "R9", "timeout err", {30'b0, r_err, r_tmo}, 32'd3);
        check(r_code == 8'h00, "R9", "timeout code", {24'b0, r_code}, 32'd0);
        check_stream(1, "R9");
        lat = 2;
    endtask

    task automatic t_busy();
        set_req(100, 8'h77, 16'h1234, 13'h0111, 2'd0, 1'b1, 1'b1);
        b_log = nlog; b_clr = nclr;
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        exp_id = (exp_id + 1) % 16;
        check(busy, "R11", "busy after accept", {31'b0, busy}, 32'd1);
        set_req(7, 8'h99, 16'h4321, 13'h0222, 2'd1, 1'b0, 1'b0);
        req_valid = 1'b1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        set_req(100, 8'h77, 16'h1234, 13'h0111, 2'd0, 1'b1, 1'b1);
        wait_end();
        check(r_done && !busy, "R11", "busy low on done", {30'b0, r_done, busy}, 32'd2);
        check_stream(3, "R11");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 17; i++) begin
            set_req(0, 8'h05, 16'h0006, 13'h0007, 2'd0, 1'b0, 1'b0);
            send();
            check(ld[b_log % 1024][7:4] == 4'(exp_id), "R10", "message id",
                  {28'b0, ld[b_log % 1024][7:4]}, 32'(exp_id));
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37) ^ (i >> 3) ^ 8'hA5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short();                 // R3 R4 R5 R6 R7, first id R10
        t_len(48, "R2");           // exact single segment
        t_len(49, "R1");           // one-byte tail segment
        t_len(0, "R6");            // empty message, transfer size 2
        t_len(2048, "R1");         // 43 segments, tail 32 bytes
        t_len(102, "R3");          // partial final dword, R5 order
        t_fail();
        t_edge();
        t_busy();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule